// File: doc/BRIEF.md
# Subword-Partitioned Vector Lane ALU

This block is the arithmetic datapath of one 64-bit vector lane. Each accepted operation works on a 64-bit word that holds one 64-bit element, two 32-bit elements or four 16-bit elements. The element size comes from a width setting that software programs once for a whole loop nest. It is not decoded from the operation code. Elements never interact: no carry, borrow or shifted bit passes from one element into the next.

The operations are wrapping or saturating add and subtract, bitwise logic, signed compares and a fixed-point multiply-add. The multiply-add forms the full-precision product, shifts it right arithmetically by a programmable amount, adds the old destination element and fits the sum to the element width. Because the shift and the sum live in a wide intermediate, any fixed-point format works without an accumulator register. Each element has a predicate bit. When the bit is clear, the element keeps its old destination value and its flag reads zero. Compares leave the data word unchanged and report one flag bit per element.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. An operand set is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure on the output stops input at once. While a result is stalled it is held without change.

Top module: `lane_alu`

## Requirements
- R1: With `elem_w`=0 the word holds four independent 16-bit elements. Element e occupies bits [16e+15:16e], and a carry out of one element never reaches the next.
- R2: With `elem_w`=1 the word holds two 32-bit elements, element e at bits [32e+31:32e]. With `elem_w`=2 or 3 the word is one 64-bit element.
- R3: Op codes: 0 add, 1 subtract (a-b), 2 AND, 3 OR, 4 XOR, 5 compare equal, 6 compare signed less-than (a<b), 7 multiply-add. With `sat_en`=0, add, subtract and multiply-add keep the low element-width bits of the exact result.
- R4: With `sat_en`=1, a signed add or subtract that overflows returns the most positive value of the element width when the true result is above it, and the most negative value when the true result is below it.
- R5: AND, OR and XOR are bitwise at every width setting and ignore `sat_en`.
- R6: A compare sets flag bit e to the outcome for element e and returns `dst_old` unchanged as the data. Flags are zero for every op that is not a compare.
- R7: Multiply-add returns ((a*b) >>> `frac_sh`) + d per element, with signed operands and d taken from `dst_old`. The sum is clamped to the element range when `sat_en`=1 and wraps otherwise.
- R8: Mask bit e gates element e. A cleared bit returns the `dst_old` element unchanged and a zero flag. Mask and flag bits above the element count are ignored or read zero.
- R9: A result appears on the cycle after its operands are accepted. `out_valid` and the data hold steady while `out_ready` is low. `in_ready` = !`out_valid` || `out_ready`.
- R10: After reset, `out_valid`, `result` and `flags` are zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set can be taken this cycle |
| src_a | input | 64 | First operand word |
| src_b | input | 64 | Second operand word |
| dst_old | input | 64 | Old destination word (addend, and the value kept for masked elements) |
| op | input | 3 | Operation code |
| elem_w | input | 2 | Element width: 0=16, 1=32, 2 or 3=64 |
| sat_en | input | 1 | Saturate instead of wrap |
| frac_sh | input | 6 | Right shift applied to the product in multiply-add |
| mask | input | 4 | Per-element predicate bits |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Downstream takes the result |
| result | output | 64 | Result word |
| flags | output | 4 | Per-element compare flags |

## Verification
Directed words place values where a wrong partition shows up. One example is an all-ones low 16-bit element plus one, which separates a correctly split carry chain from a 32-bit or 64-bit chain. Others sit at the positive and negative extremes of each width, which separates clamping from wrapping and the upper clamp from the lower one. Multiply-add is tried with Q15-style products, with shifts of zero, and with sums that overflow, so that a shift applied in the wrong place or a narrow intermediate gives a different word. A long pseudo-random stream mixes all widths, ops, masks and shifts while `out_ready` toggles, which tests element independence and the stall-hold rules together.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_CEQ = 3'd5,
    OP_CLT = 3'd6,
    OP_MAC = 3'd7
  } lane_op_e;
endpackage

// File: rtl/lane_elem.sv
module lane_elem
  import lane_alu_pkg::*;
#(
  parameter int EW  = 16,
  parameter int SHW = 6
) (
  input  logic [EW-1:0]  a,
  input  logic [EW-1:0]  b,
  input  logic [EW-1:0]  d,
  input  logic [2:0]     op,
  input  logic           sat_en,
  input  logic [SHW-1:0] shamt,
  output logic [EW-1:0]  res,
  output logic           cond
);
  localparam int PW = 2 * EW;
  localparam logic [EW-1:0] MAXV = {1'b0, {(EW-1){1'b1}}};
  localparam logic [EW-1:0] MINV = {1'b1, {(EW-1){1'b0}}};

  logic signed [EW:0]   sum_w, dif_w;
  logic signed [PW-1:0] prod, prod_sh;
  logic signed [PW:0]   acc;
  logic                 sum_ovf, dif_ovf, acc_ovf;
  lane_op_e             opc;

  assign opc = lane_op_e'(op);

  always_comb begin
    sum_w   = (EW+1)'($signed(a)) + (EW+1)'($signed(b));
    dif_w   = (EW+1)'($signed(a)) - (EW+1)'($signed(b));
    prod    = PW'($signed(a)) * PW'($signed(b));
    prod_sh = prod >>> shamt;
    acc     = (PW+1)'(prod_sh) + (PW+1)'($signed(d));
    sum_ovf = sum_w[EW] != sum_w[EW-1];
    dif_ovf = dif_w[EW] != dif_w[EW-1];
    acc_ovf = !((&acc[PW:EW-1]) || ~(|acc[PW:EW-1]));
  end

  always_comb begin
    res  = d;
    cond = 1'b0;
    unique case (opc)
      OP_ADD: res = (sat_en && sum_ovf) ? (sum_w[EW] ? MINV : MAXV) : sum_w[EW-1:0];
      OP_SUB: res = (sat_en && dif_ovf) ? (dif_w[EW] ? MINV : MAXV) : dif_w[EW-1:0];
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_CEQ: cond = (a == b);
      OP_CLT: cond = ($signed(a) < $signed(b));
      OP_MAC: res = (sat_en && acc_ovf) ? (acc[PW] ? MINV : MAXV) : acc[EW-1:0];
      default: res = d;
    endcase
  end
endmodule

// File: rtl/lane_mode_bank.sv
module lane_mode_bank #(
  parameter int DATA_W = 64,
  parameter int EW     = 16,
  parameter int SHW    = 6,
  parameter int NMASK  = 4
) (
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [2:0]        op,
  input  logic              sat_en,
  input  logic [SHW-1:0]    frac_sh,
  input  logic [NMASK-1:0]  mask,
  output logic [DATA_W-1:0] res,
  output logic [NMASK-1:0]  flg
);
  localparam int NE = DATA_W / EW;

  for (genvar e = 0; e < NE; e++) begin : g_elem
    logic [EW-1:0] e_res;
    logic          e_cond;

    lane_elem #(.EW(EW), .SHW(SHW)) u_elem (
      .a      (src_a[e*EW +: EW]),
      .b      (src_b[e*EW +: EW]),
      .d      (dst_old[e*EW +: EW]),
      .op     (op),
      .sat_en (sat_en),
      .shamt  (frac_sh),
      .res    (e_res),
      .cond   (e_cond)
    );

    assign res[e*EW +: EW] = mask[e] ? e_res : dst_old[e*EW +: EW];
    assign flg[e]          = mask[e] & e_cond;
  end

  for (genvar u = NE; u < NMASK; u++) begin : g_unused_flag
    assign flg[u] = 1'b0;
  end
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MIN_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_W-1:0]    src_a,
  input  logic [DATA_W-1:0]    src_b,
  input  logic [DATA_W-1:0]    dst_old,
  input  logic [2:0]           op,
  input  logic [1:0]           elem_w,
  input  logic                 sat_en,
  input  logic [$clog2(DATA_W)-1:0] frac_sh,
  input  logic [DATA_W/MIN_W-1:0]   mask,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_W-1:0]    result,
  output logic [DATA_W/MIN_W-1:0]   flags
);
  localparam int NSUB  = DATA_W / MIN_W;
  localparam int NMODE = $clog2(NSUB) + 1;
  localparam int SHW   = $clog2(DATA_W);

  logic [DATA_W-1:0] bank_res [NMODE];
  logic [NSUB-1:0]   bank_flg [NMODE];
  logic [1:0]        sel;
  logic [2:0]        op_q;
  logic [1:0]        sel_q;

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    lane_mode_bank #(
      .DATA_W (DATA_W),
      .EW     (MIN_W << m),
      .SHW    (SHW),
      .NMASK  (NSUB)
    ) u_bank (
      .src_a   (src_a),
      .src_b   (src_b),
      .dst_old (dst_old),
      .op      (op),
      .sat_en  (sat_en),
      .frac_sh (frac_sh),
      .mask    (mask),
      .res     (bank_res[m]),
      .flg     (bank_flg[m])
    );
  end

  assign sel      = (elem_w >= 2'(NMODE-1)) ? 2'(NMODE-1) : elem_w;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
      op_q      <= '0;
      sel_q     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= bank_res[sel];
        flags  <= bank_flg[sel];
        op_q   <= op;
        sel_q  <= sel;
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(flags));

  // R9
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R6
  flag_noncmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (op_q != OP_CEQ) && (op_q != OP_CLT) |-> flags == '0);

  // R8
  flag_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (sel_q == 2'(NMODE-1)) |-> flags[NSUB-1:1] == '0);
endmodule

// File: tb/lane_alu_tb.sv
module lane_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] src_a = '0, src_b = '0, dst_old = '0;
  logic [2:0]  op = '0;
  logic [1:0]  elem_w = '0;
  logic        sat_en = 1'b0;
  logic [5:0]  frac_sh = '0;
  logic [3:0]  mask = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] result;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  bit bp_on = 1'b0;
  bit finished = 1'b0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  logic [63:0] exp_r[$];
  logic [3:0]  exp_f[$];
  string       exp_t[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old), .op(op),
    .elem_w(elem_w), .sat_en(sat_en), .frac_sh(frac_sh), .mask(mask),
    .out_valid(out_valid), .out_ready(out_ready), .result(result), .flags(flags)
  );

  function automatic logic [63:0] next_rng(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  function automatic logic signed [129:0] sx(input logic [63:0] v, input int ew);
    logic signed [129:0] t;
    t = 130'(v);
    if (v[ew-1]) t = t - (130'sd1 <<< ew);
    return t;
  endfunction

  // Reference model built from R1..R8
  function automatic void ref_model(
    input logic [63:0] a, input logic [63:0] b, input logic [63:0] d,
    input logic [2:0] o, input logic [1:0] w, input logic s,
    input logic [5:0] sh, input logic [3:0] m,
    output logic [63:0] r, output logic [3:0] f);
    int ew, ne;
    logic [63:0] em;
    ew = (w == 2'd0) ? 16 : (w == 2'd1) ? 32 : 64;
    ne = 64 / ew;
    em = (ew == 64) ? '1 : ((64'h1 << ew) - 64'h1);
    r = '0;
    f = '0;
    for (int e = 0; e < ne; e++) begin
      logic [63:0] ar, br, dr, re;
      logic signed [129:0] sa, sb, sd, t, mx, mn;
      logic c;
      ar = (a >> (e*ew)) & em;
      br = (b >> (e*ew)) & em;
      dr = (d >> (e*ew)) & em;
      sa = sx(ar, ew); sb = sx(br, ew); sd = sx(dr, ew);
      mx = (130'sd1 <<< (ew-1)) - 130'sd1;
      mn = -(130'sd1 <<< (ew-1));
      t = '0; c = 1'b0; re = dr;
      case (o)
        3'd0: t = sa + sb;
        3'd1: t = sa - sb;
        3'd7: t = ((sa * sb) >>> sh) + sd;
        default: t = '0;
      endcase
      if (o == 3'd0 || o == 3'd1 || o == 3'd7) begin
        if (s && t > mx) t = mx;
        if (s && t < mn) t = mn;
        re = t[63:0] & em;
      end
      if (o == 3'd2) re = ar & br;
      if (o == 3'd3) re = ar | br;
      if (o == 3'd4) re = ar ^ br;
      if (o == 3'd5) c = (ar == br);
      if (o == 3'd6) c = (sa < sb);
      if (!m[e]) begin re = dr; c = 1'b0; end
      r = r | (re << (e*ew));
      f[e] = c;
    end
  endfunction

  task automatic send(input string tag, input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] d, input logic [2:0] o, input logic [1:0] w,
                      input logic s, input logic [5:0] sh, input logic [3:0] m);
    logic [63:0] er;
    logic [3:0]  ef;
    ref_model(a, b, d, o, w, s, sh, m, er, ef);
    @(negedge clk);
    src_a = a; src_b = b; dst_old = d; op = o; elem_w = w;
    sat_en = s; frac_sh = sh; mask = m; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_r.push_back(er); exp_f.push_back(ef); exp_t.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Monitor: compares at negedge, updates ready after posedge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        checks++;
        if (exp_r.size() == 0) begin
          errors++;
          $display("FAIL R9: unexpected result %h flags %h, expected none", result, flags);
        end else begin
          logic [63:0] er;
          logic [3:0]  ef;
          string       tg;
          er = exp_r.pop_front(); ef = exp_f.pop_front(); tg = exp_t.pop_front();
          if (result !== er || flags !== ef) begin
            errors++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     tg, result, flags, er, ef);
          end
        end
      end
      @(posedge clk);
      #1;
      if (bp_on) begin
        rng = next_rng(rng);
        out_ready = rng[5] | rng[9];
      end else out_ready = 1'b1;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || flags !== '0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10: valid=%b result=%h flags=%b ready=%b expected 0/0/0/1",
               out_valid, result, flags, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R9 latency: result visible one cycle after acceptance
    send("R9", 64'd5, 64'd6, 64'd0, 3'd0, 2'd2, 1'b0, 6'd0, 4'hF);
    checks++;
    if (out_valid !== 1'b1 || result !== 64'd11) begin
      errors++;
      $display("FAIL R9: valid=%b result=%h expected 1/%h", out_valid, result, 64'd11);
    end

    // R1 carry isolation at 16 bits
    send("R1", 64'h0001_0002_7FFF_FFFF, 64'h0001_0001_0001_0001, '0, 3'd0, 2'd0, 1'b0, 6'd0, 4'hF);
    send("R1", 64'h0000_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF, '0, 3'd1, 2'd0, 1'b0, 6'd0, 4'hF);
    // R2 same words at 32 and 64 bits
    send("R2", 64'h0001_0002_7FFF_FFFF, 64'h0001_0001_0001_0001, '0, 3'd0, 2'd1, 1'b0, 6'd0, 4'hF);
    send("R2", 64'h0001_0002_7FFF_FFFF, 64'h0001_0001_0001_0001, '0, 3'd0, 2'd2, 1'b0, 6'd0, 4'hF);
    send("R2", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, '0, 3'd0, 2'd3, 1'b0, 6'd0, 4'hF);
    // R3 wrap
    send("R3", 64'h8000_8000_7FFF_0000, 64'h0001_0001_FFFF_0001, '0, 3'd1, 2'd0, 1'b0, 6'd0, 4'hF);
    // R4 saturation per width and direction
    send("R4", 64'h8000_8000_7FFF_7FFF, 64'h0001_FFFF_0001_8000, '0, 3'd0, 2'd0, 1'b1, 6'd0, 4'hF);
    send("R4", 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, '0, 3'd1, 2'd1, 1'b1, 6'd0, 4'hF);
    send("R4", 64'h7FFF_FFFF_FFFF_FFF0, 64'h100, '0, 3'd0, 2'd2, 1'b1, 6'd0, 4'hF);
    send("R4", 64'h8000_0000_0000_0000, 64'h1, '0, 3'd1, 2'd2, 1'b1, 6'd0, 4'hF);
    // R5 logic ignores saturation
    send("R5", 64'hF0F0_1234_AAAA_0000, 64'hFF00_FFFF_5555_FFFF, '0, 3'd2, 2'd0, 1'b1, 6'd0, 4'hF);
    send("R5", 64'hF0F0_1234_AAAA_0000, 64'hFF00_FFFF_5555_FFFF, '0, 3'd3, 2'd1, 1'b1, 6'd0, 4'hF);
    send("R5", 64'hF0F0_1234_AAAA_0000, 64'hFF00_FFFF_5555_FFFF, '0, 3'd4, 2'd2, 1'b0, 6'd0, 4'hF);
    // R6 compares
    send("R6", 64'h1234_0005_8000_7FFF, 64'h1234_0006_7FFF_7FFF, 64'hDEAD_BEEF_CAFE_F00D, 3'd5, 2'd0, 1'b0, 6'd0, 4'hF);
    send("R6", 64'h1234_0005_8000_7FFF, 64'h1234_0006_7FFF_7FFF, 64'hDEAD_BEEF_CAFE_F00D, 3'd6, 2'd0, 1'b0, 6'd0, 4'hF);
    send("R6", 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0001, 64'h0, 3'd6, 2'd1, 1'b0, 6'd0, 4'hF);
    // R7 multiply-add
    send("R7", 64'h4000_C000_4000_7FFF, 64'h4000_4000_8000_7FFF, 64'h0001_0000_0000_0010, 3'd7, 2'd0, 1'b0, 6'd15, 4'hF);
    send("R7", 64'h4000_C000_8000_7FFF, 64'h4000_4000_8000_7FFF, 64'h7000_8000_0000_0010, 3'd7, 2'd0, 1'b1, 6'd14, 4'hF);
    send("R7", 64'h0000_0003_FFFF_FFFE, 64'h0000_0007_0000_0005, 64'h0000_0001_0000_0002, 3'd7, 2'd1, 1'b0, 6'd0, 4'hF);
    send("R7", 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, 64'h7000_0000_0000_0000, 3'd7, 2'd2, 1'b1, 6'd62, 4'hF);
    // R8 masking
    send("R8", 64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001, 64'hAAAA_BBBB_CCCC_DDDD, 3'd0, 2'd0, 1'b0, 6'd0, 4'b0101);
    send("R8", 64'h1234_1234_5678_5678, 64'h1234_1234_5678_5678, 64'hAAAA_BBBB_CCCC_DDDD, 3'd5, 2'd1, 1'b0, 6'd0, 4'b1110);
    send("R8", 64'h5, 64'h5, 64'h9, 3'd5, 2'd2, 1'b0, 6'd0, 4'b1110);
    send("R8", 64'h5, 64'h5, 64'h9, 3'd5, 2'd3, 1'b0, 6'd0, 4'b0001);

    // R9 with back-pressure, mixed random stream (R1..R8)
    bp_on = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b, d, k;
      rng = next_rng(rng); a = rng;
      rng = next_rng(rng); b = rng;
      rng = next_rng(rng); d = rng;
      rng = next_rng(rng); k = rng;
      if (k[40]) b = a ^ {48'h0, k[63:48]};
      send("R9 stream", a, b, d, k[2:0], k[4:3], k[5], k[6] ? k[12:7] : {2'b0, k[11:8]}, k[16:13]);
    end
    bp_on = 1'b0;
    while (exp_r.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule